// File: doc/BRIEF.md
# Timer Compare Output Unit

This block is one compare channel with its own pair of 16-bit up-counting timers. The channel holds a compare value and a 4-bit mode. On every clock it checks that value against whichever timer its select field names. When the chosen timer first equals the compare value, the channel acts on its output latch. Depending on the mode it sets the latch, clears it, toggles it, or leaves it as it is. It also raises a sticky interrupt flag, which software clears with a write-one-to-clear strobe.

One mode turns the compare value into a period register. Each match sends the selected timer back to zero, and that reset does not raise the timer's own wrap flag. When the channel is built as the second channel and the converter enable is high, the same match also gives a one-cycle converter start pulse. Registers are written through single-cycle strobes and take effect at the next clock edge. Each timer counts while its run input is high.

Top module: `cmp_out_unit`

## Requirements
- R1: After reset the output latch, interrupt flag, start pulse, both timers, both wrap flags, the compare value, the mode and the select field are all zero.
- R2: Select field decode: bit 1 set picks timer B. Bit 0 set picks timer B only when CHAN_IDX is nonzero (the second channel). Otherwise timer A is compared.
- R3: Mode 4'b1000 sets the latch on a match, 4'b1001 clears it and 4'b0010 toggles it. The change shows in the cycle after the match cycle.
- R4: A match event happens only in a cycle where the timer equals the compare value and did not equal it in the previous cycle. A timer held on the compare value gives exactly one action.
- R5: Every match event in one of the five active modes (4'b1000, 4'b1001, 4'b0010, 4'b1010, 4'b1011) sets the flag. Under any other mode value a match changes neither the flag nor the latch.
- R6: In mode 4'b1010 a match sets the flag and leaves the latch unchanged.
- R7: Writing 4'b0000 to the mode register forces the latch low at the next edge. Writing any other value leaves the latch as it is.
- R8: In mode 4'b1011 a match loads zero into the selected timer at the next edge instead of counting. The other timer and the latch are unaffected.
- R9: A timer that counts from 16'hFFFF to zero sets its wrap flag. A reset caused by a trigger match never sets it. A per-timer write-one-to-clear strobe clears the flag, and a wrap in the same cycle wins.
- R10: The converter start output pulses high for exactly one cycle after a trigger match when CHAN_IDX is nonzero and the converter enable is high. It never pulses for channel 0.
- R11: The interrupt flag stays set until the clear strobe is given. A match and a clear in the same cycle leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Mode value to write |
| cmpv_wr | input | 1 | Compare value write strobe |
| cmpv_wdata | input | 16 | Compare value to write |
| tsel_wr | input | 1 | Timer select write strobe |
| tsel_wdata | input | 2 | Timer select field to write |
| flag_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| conv_en | input | 1 | Converter enable that gates the start pulse |
| tmr_run | input | 2 | Run enable per timer (bit 0 = A, bit 1 = B) |
| tmr_wrap_clr | input | 2 | Write-one-to-clear per timer wrap flag |
| cmp_out | output | 1 | Compare output latch |
| cmp_flag | output | 1 | Interrupt flag |
| conv_start | output | 1 | One-cycle converter start pulse |
| tmr_a_val | output | 16 | Timer A count |
| tmr_b_val | output | 16 | Timer B count |
| tmr_wrap | output | 2 | Wrap flag per timer |

## Verification
Several rules are checked on every cycle by the assertions. A match event never repeats in the next cycle. The start pulse lasts one cycle and never appears on channel 0. A set flag survives any cycle without a clear. Writing zero to the mode drops the latch, and inactive or flag-only modes never move it. A trigger reset lands on zero without raising the wrap flag. The bench's scenarios are needed to show the rest: which timer each select code picks, the toggle happening once on a held timer, the set-beats-clear ordering with exact timing, the period that the trigger imposes, and a real wrap from 16'hFFFF.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam logic [3:0] MODE_SET  = 4'b1000;
    localparam logic [3:0] MODE_CLR  = 4'b1001;
    localparam logic [3:0] MODE_TGL  = 4'b0010;
    localparam logic [3:0] MODE_IRQ  = 4'b1010;
    localparam logic [3:0] MODE_TRIG = 4'b1011;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_SET,
        ACT_CLR,
        ACT_TGL,
        ACT_IRQ,
        ACT_TRIG
    } act_e;

    function automatic act_e decode_mode(input logic [3:0] m);
        case (m)
            MODE_SET:  return ACT_SET;
            MODE_CLR:  return ACT_CLR;
            MODE_TGL:  return ACT_TGL;
            MODE_IRQ:  return ACT_IRQ;
            MODE_TRIG: return ACT_TRIG;
            default:   return ACT_NONE;
        endcase
    endfunction

    typedef struct packed {
        logic [3:0] mode;
        logic [1:0] tsel;
        logic       prev;
        logic       latch;
        logic       flag;
        logic       start;
    } chan_st_t;

endpackage

// File: rtl/cmp_timer.sv
module cmp_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         zero_ld,
    input  logic         wrap_clr,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         wrap;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    wrap_hit;

    always_comb begin
        st_d     = st_q;
        wrap_hit = run && !zero_ld && (&st_q.cnt);
        if (zero_ld) begin
            st_d.cnt = '0;
        end else if (run) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (wrap_hit) begin
            st_d.wrap = 1'b1;
        end else if (wrap_clr) begin
            st_d.wrap = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign wrap = st_q.wrap;

    // R8: a trigger reset lands on zero
    assert_zero_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        zero_ld |=> (cnt == '0));

    // R9: a trigger reset never raises the wrap flag
    assert_no_wrap_on_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_ld && !wrap) |=> !wrap);

endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
    import cmp_pkg::*;
#(
    parameter int W        = 16,
    parameter int CHAN_IDX = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_wr,
    input  logic [3:0]   mode_wdata,
    input  logic         cmpv_wr,
    input  logic [W-1:0] cmpv_wdata,
    input  logic         tsel_wr,
    input  logic [1:0]   tsel_wdata,
    input  logic         flag_clr,
    input  logic         conv_en,
    input  logic [W-1:0] tmr_a,
    input  logic [W-1:0] tmr_b,
    output logic         use_b,
    output logic         tmr_zero,
    output logic         latch_out,
    output logic         flag_out,
    output logic         start_out
);

    localparam logic IS_SECOND = (CHAN_IDX != 0);

    chan_st_t     st_d, st_q;
    logic [W-1:0] cmpv_d, cmpv_q;
    logic [W-1:0] tmr_sel;
    logic         match_now;
    logic         evt;
    act_e         act;

    generate
        if (IS_SECOND) begin : g_sel_second
            assign use_b = st_q.tsel[1] | st_q.tsel[0];
        end else begin : g_sel_first
            assign use_b = st_q.tsel[1];
        end
    endgenerate

    assign tmr_sel   = use_b ? tmr_b : tmr_a;
    assign match_now = (tmr_sel == cmpv_q);
    assign evt       = match_now && !st_q.prev;
    assign act       = decode_mode(st_q.mode);
    assign tmr_zero  = evt && (act == ACT_TRIG);

    always_comb begin
        st_d       = st_q;
        cmpv_d     = cmpv_q;
        st_d.prev  = match_now;
        st_d.start = 1'b0;
        if (evt) begin
            case (act)
                ACT_SET:  st_d.latch = 1'b1;
                ACT_CLR:  st_d.latch = 1'b0;
                ACT_TGL:  st_d.latch = ~st_q.latch;
                ACT_TRIG: st_d.start = conv_en & IS_SECOND;
                default:  st_d.latch = st_q.latch;
            endcase
        end
        if (evt && (act != ACT_NONE)) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
        if (mode_wr) begin
            st_d.mode = mode_wdata;
            if (mode_wdata == 4'b0000) begin
                st_d.latch = 1'b0;
            end
        end
        if (tsel_wr) begin
            st_d.tsel = tsel_wdata;
        end
        if (cmpv_wr) begin
            cmpv_d = cmpv_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            cmpv_q <= '0;
        end else begin
            st_q   <= st_d;
            cmpv_q <= cmpv_d;
        end
    end

    assign latch_out = st_q.latch;
    assign flag_out  = st_q.flag;
    assign start_out = st_q.start;

    // R4: one event per arrival at the compare value
    assert_single_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

    // R5: inactive modes leave the latch alone
    assert_idle_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_NONE && !mode_wr) |=> $stable(latch_out));

    // R6: flag-only mode leaves the latch alone
    assert_irq_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_IRQ && !mode_wr) |=> $stable(latch_out));

    // R7: zero written to the mode drops the latch
    assert_zero_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_wdata == 4'b0000) |=> !latch_out);

    // R10: the start pulse lasts one cycle
    assert_start_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_out |=> !start_out);

    // R10: the start pulse needs a trigger match on the second channel
    assert_start_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_out) |-> (IS_SECOND && $past(tmr_zero)));

    // R11: the flag holds until cleared
    assert_flag_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_out && !flag_clr) |=> flag_out);

endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit #(
    parameter int TMR_W    = 16,
    parameter int CHAN_IDX = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [3:0]       mode_wdata,
    input  logic             cmpv_wr,
    input  logic [TMR_W-1:0] cmpv_wdata,
    input  logic             tsel_wr,
    input  logic [1:0]       tsel_wdata,
    input  logic             flag_clr,
    input  logic             conv_en,
    input  logic [1:0]       tmr_run,
    input  logic [1:0]       tmr_wrap_clr,
    output logic             cmp_out,
    output logic             cmp_flag,
    output logic             conv_start,
    output logic [TMR_W-1:0] tmr_a_val,
    output logic [TMR_W-1:0] tmr_b_val,
    output logic [1:0]       tmr_wrap
);

    localparam int NUM_TMR = 2;

    logic [TMR_W-1:0] cnt [NUM_TMR];
    logic [NUM_TMR-1:0] zero_ld;
    logic use_b;
    logic tmr_zero;

    generate
        for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
            assign zero_ld[i] = tmr_zero && (use_b == (i == 1));
            cmp_timer #(.W(TMR_W)) u_tmr (
                .clk      (clk),
                .rst_n    (rst_n),
                .run      (tmr_run[i]),
                .zero_ld  (zero_ld[i]),
                .wrap_clr (tmr_wrap_clr[i]),
                .cnt      (cnt[i]),
                .wrap     (tmr_wrap[i])
            );
        end
    endgenerate

    cmp_channel #(.W(TMR_W), .CHAN_IDX(CHAN_IDX)) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .cmpv_wr    (cmpv_wr),
        .cmpv_wdata (cmpv_wdata),
        .tsel_wr    (tsel_wr),
        .tsel_wdata (tsel_wdata),
        .flag_clr   (flag_clr),
        .conv_en    (conv_en),
        .tmr_a      (cnt[0]),
        .tmr_b      (cnt[1]),
        .use_b      (use_b),
        .tmr_zero   (tmr_zero),
        .latch_out  (cmp_out),
        .flag_out   (cmp_flag),
        .start_out  (conv_start)
    );

    assign tmr_a_val = cnt[0];
    assign tmr_b_val = cnt[1];

endmodule

// File: tb/cmp_out_unit_tb.sv
module cmp_out_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int WD_CYCLES  = 190000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_wr = 1'b0;
    logic [3:0]   mode_wdata = '0;
    logic         cmpv_wr = 1'b0;
    logic [W-1:0] cmpv_wdata = '0;
    logic         tsel_wr = 1'b0;
    logic [1:0]   tsel_wdata = '0;
    logic         flag_clr = 1'b0;
    logic         conv_en = 1'b0;
    logic [1:0]   tmr_run = '0;
    logic [1:0]   tmr_wrap_clr = '0;
    logic         cmp_out, cmp_flag, conv_start;
    logic [W-1:0] tmr_a_val, tmr_b_val;
    logic [1:0]   tmr_wrap;

    int total = 0;
    int bad = 0;

    cmp_out_unit #(.TMR_W(W), .CHAN_IDX(1)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .cmpv_wr(cmpv_wr), .cmpv_wdata(cmpv_wdata),
        .tsel_wr(tsel_wr), .tsel_wdata(tsel_wdata),
        .flag_clr(flag_clr), .conv_en(conv_en),
        .tmr_run(tmr_run), .tmr_wrap_clr(tmr_wrap_clr),
        .cmp_out(cmp_out), .cmp_flag(cmp_flag), .conv_start(conv_start),
        .tmr_a_val(tmr_a_val), .tmr_b_val(tmr_b_val), .tmr_wrap(tmr_wrap)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int   m_t [2];
    bit   m_wrap [2];
    int   m_cmp, m_mode, m_tsel;
    bit   m_prev, m_latch, m_flag, m_start;

    function automatic bit active_mode(int m);
        return (m == 8) || (m == 9) || (m == 2) || (m == 10) || (m == 11);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_t[0] = 0; m_t[1] = 0; m_wrap[0] = 0; m_wrap[1] = 0;
            m_cmp = 0; m_mode = 0; m_tsel = 0;
            m_prev = 0; m_latch = 0; m_flag = 0; m_start = 0;
        end else begin
            int  sel;
            bit  hit, ev, trig;
            sel  = (m_tsel != 0) ? 1 : 0;
            hit  = (m_t[sel] == m_cmp);
            ev   = hit && !m_prev;
            trig = ev && (m_mode == 11);
            m_start = trig && conv_en;
            if (ev) begin
                if (m_mode == 8) m_latch = 1;
                else if (m_mode == 9) m_latch = 0;
                else if (m_mode == 2) m_latch = !m_latch;
            end
            if (ev && active_mode(m_mode)) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            for (int i = 0; i < 2; i++) begin
                bit z;
                z = trig && (sel == i);
                if (tmr_run[i] && !z && m_t[i] == 65535) m_wrap[i] = 1;
                else if (tmr_wrap_clr[i]) m_wrap[i] = 0;
                if (z) m_t[i] = 0;
                else if (tmr_run[i]) m_t[i] = (m_t[i] + 1) % 65536;
            end
            m_prev = hit;
            if (mode_wr) begin
                m_mode = int'(mode_wdata);
                if (mode_wdata == 4'b0000) m_latch = 0;
            end
            if (tsel_wr) m_tsel = int'(tsel_wdata);
            if (cmpv_wr) m_cmp = int'(cmpv_wdata);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R3 latch vs model", int'(cmp_out), int'(m_latch));
        check("R5 flag vs model", int'(cmp_flag), int'(m_flag));
        check("R10 start vs model", int'(conv_start), int'(m_start));
        check("R8 timer A vs model", int'(tmr_a_val), m_t[0]);
        check("R8 timer B vs model", int'(tmr_b_val), m_t[1]);
        check("R9 wrap A vs model", int'(tmr_wrap[0]), int'(m_wrap[0]));
        check("R9 wrap B vs model", int'(tmr_wrap[1]), int'(m_wrap[1]));
    endtask

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic wr_mode(input logic [3:0] v);
        mode_wr = 1'b1; mode_wdata = v; tick(1); mode_wr = 1'b0;
    endtask

    task automatic wr_cmp(input int v);
        cmpv_wr = 1'b1; cmpv_wdata = W'(v); tick(1); cmpv_wr = 1'b0;
    endtask

    task automatic wr_tsel(input logic [1:0] v);
        tsel_wr = 1'b1; tsel_wdata = v; tick(1); tsel_wr = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    endtask

    // fresh match against a held timer value
    task automatic hit_value(input int v);
        wr_cmp((v + 1) % 65536);
        wr_cmp(v);
        tick(2);
    endtask

    task automatic run_all();
        int max_a, pulses;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 latch", int'(cmp_out), 0);
        check("R1 flag", int'(cmp_flag), 0);
        check("R1 start", int'(conv_start), 0);
        check("R1 timer A", int'(tmr_a_val), 0);
        check("R1 wrap", int'(tmr_wrap), 0);

        // R4 toggle on held timer: exactly one toggle
        wr_mode(4'b0010);
        wr_cmp(3);
        wr_cmp(0);
        tick(8);
        check("R4 single toggle", int'(cmp_out), 1);
        check("R5 flag on toggle", int'(cmp_flag), 1);
        clr_flag();
        check("R11 flag cleared", int'(cmp_flag), 0);

        // R3 clear then set
        wr_mode(4'b1001);
        wr_cmp(7);
        tmr_run = 2'b01;
        tick(10);
        tmr_run = 2'b00;
        tick(1);
        check("R3 clear on match", int'(cmp_out), 0);
        wr_mode(4'b1000);
        hit_value(m_t[0]);
        check("R3 set on match", int'(cmp_out), 1);

        // R7 nonzero write keeps latch, zero write drops it
        wr_mode(4'b1001);
        tick(1);
        check("R7 nonzero mode write keeps latch", int'(cmp_out), 1);
        wr_mode(4'b0000);
        check("R7 zero mode write clears latch", int'(cmp_out), 0);

        // R6 flag only
        clr_flag();
        wr_mode(4'b1010);
        hit_value(m_t[0]);
        check("R6 flag set", int'(cmp_flag), 1);
        check("R6 latch unchanged", int'(cmp_out), 0);

        // R5 inactive mode: latch held high, no flag
        wr_mode(4'b1000);
        hit_value(m_t[0]);
        clr_flag();
        wr_mode(4'b0101);
        hit_value(m_t[0]);
        check("R5 inactive mode no flag", int'(cmp_flag), 0);
        check("R5 inactive mode latch held", int'(cmp_out), 1);

        // R2 select decode on the second channel
        tmr_run = 2'b10;
        tick(4);
        tmr_run = 2'b00;
        tick(1);
        wr_mode(4'b1010);
        wr_tsel(2'b01);
        hit_value(m_t[0]);
        check("R2 select 01 ignores timer A", int'(cmp_flag), 0);
        hit_value(m_t[1]);
        check("R2 select 01 uses timer B", int'(cmp_flag), 1);
        clr_flag();
        wr_tsel(2'b10);
        hit_value(m_t[0]);
        check("R2 select 10 ignores timer A", int'(cmp_flag), 0);
        wr_tsel(2'b00);
        hit_value(m_t[0]);
        check("R2 select 00 uses timer A", int'(cmp_flag), 1);

        // R11 set beats clear in the same cycle
        clr_flag();
        wr_cmp(m_t[0] + 1);
        cmpv_wr = 1'b1; cmpv_wdata = W'(m_t[0]); tick(1); cmpv_wr = 1'b0;
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        check("R11 set wins over clear", int'(cmp_flag), 1);

        // R8 R9 R10 trigger as period register
        tmr_wrap_clr = 2'b11; tick(1); tmr_wrap_clr = 2'b00;
        conv_en = 1'b1;
        wr_cmp(40);
        wr_mode(4'b1011);
        tmr_run = 2'b11;
        max_a = 0; pulses = 0;
        for (int k = 0; k < 150; k++) begin
            tick(1);
            if (int'(tmr_a_val) > max_a) max_a = int'(tmr_a_val);
            if (conv_start) pulses++;
        end
        check("R8 period bounded by compare value", max_a, 40);
        check("R10 start pulses with enable", int'(pulses >= 3), 1);
        check("R9 trigger reset no wrap flag", int'(tmr_wrap[0]), 0);
        conv_en = 1'b0;
        pulses = 0;
        for (int k = 0; k < 100; k++) begin
            tick(1);
            if (conv_start) pulses++;
        end
        check("R10 no start pulse when disabled", pulses, 0);

        // R9 genuine wrap
        wr_mode(4'b0000);
        tmr_run = 2'b01;
        tmr_wrap_clr = 2'b01; tick(1); tmr_wrap_clr = 2'b00;
        for (int k = 0; k < 70000 && m_t[0] != 65535; k++) tick(1);
        tick(1);
        check("R9 wrap flag set", int'(tmr_wrap[0]), 1);
        check("R9 timer A wrapped", int'(tmr_a_val), 0);
        tmr_run = 2'b00;
        tmr_wrap_clr = 2'b01; tick(1); tmr_wrap_clr = 2'b00;
        check("R9 wrap flag cleared", int'(tmr_wrap[0]), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                #(CLK_PERIOD * WD_CYCLES);
                total++;
                bad++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule